// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

This block is a watchdog for a processor subsystem. A down-counter is loaded from a programmable reload register and counts down by one on each cycle where the tick-enable input is high. Software keeps the system alive by writing a fixed key word to a restart register before the count reaches zero. If the count does reach zero, the block latches a status flag. It then drives any enabled mix of three alarms: a one-cycle system-reset request, an interrupt, and an external signal.

The interrupt and the external signal last for a programmed number of ticks. All access goes through a word-wide register bus with one read or write per cycle. Read data is combinational in the cycle where the read strobe is high. The count logic is a three-state machine:

- **ST_OFF**: counting is disabled.
- **ST_COUNT**: the counter is running.
- **ST_FIRED**: the count has expired and is held at zero.

The transitions are:

- **ARM**: an enable bit written from 0 to 1 moves ST_OFF to ST_COUNT.
- **KICK**: a valid restart reloads the counter. In ST_COUNT it stays in ST_COUNT. In ST_FIRED it returns to ST_COUNT.
- **EXPIRE**: a tick at a count of 1 moves ST_COUNT to ST_FIRED.
- **DISARM**: writing the enable bit to 0 moves ST_COUNT or ST_FIRED to ST_OFF.

Top module: `wdog_top`

## Requirements
- R1: After reset, control (offset 0x0C) reads 0 and status (0x10) reads 0. The reload value (0x04) reads 0x03EF1480 and the alarm length (0x18) reads 4. All three alarm outputs are low.
- R2: Offset 0x1C reads the constant 0x00010601. Offsets 0x08 and 0x14 read as 0. Any offset at or above 0x20, or not word aligned, reads 0, and writes to it change nothing.
- R3: While control bit 0 (run) is 0, offset 0x00 reads the reload value.
- R4: Writing control with bit 0 set while run was 0 loads the counter from the reload value, and a reload of 0 loads 1. Writing control again while run is already 1 leaves the counter untouched.
- R5: While run is 1, the counter drops by one on each cycle with tick_en high. Clearing run stops counting.
- R6: A write of 0x00005AB9 to offset 0x08 while run is 1 reloads the counter. Any other value, or any write while run is 0, has no effect.
- R7: When the counter steps from 1 to 0, status bit 1 is set, and the counter then holds 0 until it is restarted or re-armed.
- R8: On expiry, wdt_rst_req pulses high for exactly one clock, and only if control bit 1 is set.
- R9: On expiry, an internal alarm window opens for max(length, 1) ticks. wdt_irq is high during the window when control bit 2 is set. wdt_ext is high during the window when control bit 3 is set.
- R10: Writing offset 0x14 clears status bit 1 when write-data bit 1 is 1. An expiry in the same cycle wins, and the flag stays set.
- R11: A valid restart in the same cycle as the final tick reloads the counter, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count tick qualifier |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| wdt_rst_req | output | 1 | One-cycle system-reset request |
| wdt_irq | output | 1 | Interrupt alarm |
| wdt_ext | output | 1 | External alarm |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the final tick that causes expiry and a status-clear write. The second pair is that same final tick and a keyed restart. Directed sequences arm the counter at 1 or 3 and issue the clear or the restart in the cycle whose tick would reach zero. A reference model then judges the result: the status flag must stay set in the first case, and in the second the counter must read the reload value with no alarm. Random traffic mixes ticks with every register write, so these collisions recur many times and are compared cycle by cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int          DATA_W     = 32;
    localparam logic [31:0] KICK_KEY   = 32'h0000_5AB9;
    localparam logic [31:0] REV_CODE   = 32'h0001_0601;
    localparam logic [31:0] RELOAD_RST = 32'h03EF_1480;
    localparam logic [31:0] ALEN_RST   = 32'd4;

    // word index = byte offset / 4
    localparam logic [2:0] IDX_COUNT  = 3'd0;
    localparam logic [2:0] IDX_RELOAD = 3'd1;
    localparam logic [2:0] IDX_KICK   = 3'd2;
    localparam logic [2:0] IDX_CTRL   = 3'd3;
    localparam logic [2:0] IDX_STAT   = 3'd4;
    localparam logic [2:0] IDX_CLR    = 3'd5;
    localparam logic [2:0] IDX_ALEN   = 3'd6;
    localparam logic [2:0] IDX_REV    = 3'd7;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRED = 2'd2
    } cnt_state_e;

    typedef struct packed {
        logic clk_sel;   // bit 4
        logic ext_en;    // bit 3
        logic irq_en;    // bit 2
        logic rst_en;    // bit 1
        logic run;       // bit 0
    } ctrl_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              expire,
    input  logic [DATA_W-1:0] cnt_val,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] alen_q,
    output logic              status_q,
    output logic              ctrl_wr,
    output logic              kick_ok,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int IDX_LSB = 2;
    localparam int MAP_TOP = IDX_LSB + 3;

    logic       mapped;
    logic [2:0] idx;
    logic       reload_wr, alen_wr, clr_wr, kick_wr;

    always_comb begin
        mapped    = (bus_addr[IDX_LSB-1:0] == '0) && ((bus_addr >> MAP_TOP) == '0);
        idx       = bus_addr[MAP_TOP-1:IDX_LSB];
        ctrl_wr   = bus_wr && mapped && (idx == IDX_CTRL);
        reload_wr = bus_wr && mapped && (idx == IDX_RELOAD);
        alen_wr   = bus_wr && mapped && (idx == IDX_ALEN);
        clr_wr    = bus_wr && mapped && (idx == IDX_CLR);
        kick_wr   = bus_wr && mapped && (idx == IDX_KICK);
        kick_ok   = kick_wr && ctrl_q.run && (bus_wdata == KICK_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= RELOAD_RST;
            alen_q   <= ALEN_RST;
        end else begin
            if (ctrl_wr)   ctrl_q   <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
            if (reload_wr) reload_q <= bus_wdata;
            if (alen_wr)   alen_q   <= bus_wdata;
        end
    end

    // expiry has priority over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    status_q <= 1'b0;
        else if (expire)               status_q <= 1'b1;
        else if (clr_wr && bus_wdata[1]) status_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && mapped) begin
            unique case (idx)
                IDX_COUNT:  bus_rdata = ctrl_q.run ? cnt_val : reload_q;
                IDX_RELOAD: bus_rdata = reload_q;
                IDX_CTRL:   bus_rdata = DATA_W'(ctrl_q);
                IDX_STAT:   bus_rdata = DATA_W'({status_q, 1'b0});
                IDX_ALEN:   bus_rdata = alen_q;
                IDX_REV:    bus_rdata = REV_CODE;
                IDX_KICK, IDX_CLR: bus_rdata = '0;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ctrl_wr,
    input  logic              run_wdata,
    input  logic              kick_ok,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire,
    output cnt_state_e        state_q
);
    cnt_state_e        state_d;
    logic [DATA_W-1:0] load_val;
    logic              arm, disarm;

    always_comb begin
        load_val = (reload == '0) ? DATA_W'(1) : reload;
        arm      = ctrl_wr && run_wdata;
        disarm   = ctrl_wr && !run_wdata;
    end

    // next state and expiry strobe
    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_OFF:   if (arm) state_d = ST_COUNT;
            ST_COUNT: begin
                if (disarm)                             state_d = ST_OFF;
                else if (!kick_ok && tick_en && cnt_q == DATA_W'(1)) begin
                    state_d = ST_FIRED;
                    expire  = 1'b1;
                end
            end
            ST_FIRED: begin
                if (disarm)       state_d = ST_OFF;
                else if (kick_ok) state_d = ST_COUNT;
            end
            default:              state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF:   if (arm) cnt_q <= load_val;
                ST_COUNT: begin
                    if (disarm)       cnt_q <= cnt_q;
                    else if (kick_ok) cnt_q <= load_val;
                    else if (tick_en) cnt_q <= cnt_q - DATA_W'(1);
                end
                ST_FIRED: if (!disarm && kick_ok) cnt_q <= load_val;
                default:  cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              expire,
    input  logic [DATA_W-1:0] alen,
    input  logic              rst_en,
    input  logic              irq_en,
    input  logic              ext_en,
    output logic              pulse_active,
    output logic              wdt_rst_req,
    output logic              wdt_irq,
    output logic              wdt_ext
);
    logic [DATA_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     win_q <= '0;
        else if (expire)                win_q <= (alen == '0) ? DATA_W'(1) : alen;
        else if (win_q != '0 && tick_en) win_q <= win_q - DATA_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_rst_req <= 1'b0;
        else        wdt_rst_req <= expire && rst_en;
    end

    always_comb begin
        pulse_active = (win_q != '0);
        wdt_irq      = pulse_active && irq_en;
        wdt_ext      = pulse_active && ext_en;
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_req,
    output logic              wdt_irq,
    output logic              wdt_ext
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q, alen_q, cnt_val;
    logic              status_flag, ctrl_wr, kick_ok, expire, pulse_active;
    cnt_state_e        cnt_state;

    wdog_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .expire(expire), .cnt_val(cnt_val),
        .ctrl_q(ctrl_q), .reload_q(reload_q), .alen_q(alen_q), .status_q(status_flag),
        .ctrl_wr(ctrl_wr), .kick_ok(kick_ok), .bus_rdata(bus_rdata)
    );

    wdog_down_cnt u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .ctrl_wr(ctrl_wr), .run_wdata(bus_wdata[0]), .kick_ok(kick_ok),
        .reload(reload_q), .cnt_q(cnt_val), .expire(expire), .state_q(cnt_state)
    );

    wdog_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .expire(expire), .alen(alen_q),
        .rst_en(ctrl_q.rst_en), .irq_en(ctrl_q.irq_en), .ext_en(ctrl_q.ext_en),
        .pulse_active(pulse_active),
        .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq), .wdt_ext(wdt_ext)
    );
endmodule

// File: rtl/wdog_checks.sv
module wdog_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        ctrl_wr,
    input logic        kick_ok,
    input logic        expire,
    input logic [31:0] cnt_val,
    input logic        run,
    input logic        rst_en,
    input logic        irq_en,
    input logic        status_flag,
    input logic        wdt_rst_req,
    input logic        wdt_irq
);
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((!tick_en || !run) && !kick_ok && !ctrl_wr) |=> $stable(cnt_val));

    a_r7_expire_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status_flag);

    a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_val == 32'd0 && !kick_ok && !ctrl_wr) |=> (cnt_val == 32'd0));

    a_r8_single_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    a_r8_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> ($past(expire) && $past(rst_en)));

    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq) |-> ($past(expire) || $past(!irq_en)));

    a_r11_kick_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        kick_ok |-> !expire);
endmodule

bind wdog_top wdog_checks u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_wr(ctrl_wr), .kick_ok(kick_ok),
    .expire(expire), .cnt_val(cnt_val), .run(ctrl_q.run), .rst_en(ctrl_q.rst_en),
    .irq_en(ctrl_q.irq_en), .status_flag(status_flag),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
);

// File: tb/wdog_top_test.sv
module wdog_top_test;
    localparam int CLK_P = 10;
    localparam logic [31:0] KEY = 32'h0000_5AB9;

    logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req, wdt_irq, wdt_ext;

    int vectors = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wdog_top uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq), .wdt_ext(wdt_ext)
    );

    // reference model
    logic [4:0]  m_ctrl;
    logic [31:0] m_rel, m_len, m_cnt, m_win;
    logic        m_st, m_req;

    function automatic logic [31:0] at_least1(logic [31:0] v);
        return (v == 0) ? 32'd1 : v;
    endfunction

    function automatic logic [31:0] m_read(logic rd, logic [7:0] a);
        if (!rd) return 32'd0;
        case (a)
            8'h00: return m_ctrl[0] ? m_cnt : m_rel;
            8'h04: return m_rel;
            8'h0C: return {27'd0, m_ctrl};
            8'h10: return {30'd0, m_st, 1'b0};
            8'h18: return m_len;
            8'h1C: return 32'h0001_0601;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_rel = 32'h03EF_1480; m_len = 32'd4;
            m_cnt = '0; m_win = '0; m_st = 1'b0; m_req = 1'b0;
        end else begin
            logic wc, kick, exp_now;
            wc      = bus_wr && bus_addr == 8'h0C;
            kick    = bus_wr && bus_addr == 8'h08 && bus_wdata == KEY && m_ctrl[0];
            exp_now = 1'b0;
            if (wc && bus_wdata[0] && !m_ctrl[0]) m_cnt = at_least1(m_rel);
            else if (kick) m_cnt = at_least1(m_rel);
            else if (m_ctrl[0] && !(wc && !bus_wdata[0]) && tick_en && m_cnt != 0) begin
                m_cnt = m_cnt - 1;
                exp_now = (m_cnt == 0);
            end
            m_req = exp_now && m_ctrl[1];
            if (exp_now) m_win = at_least1(m_len);
            else if (m_win != 0 && tick_en) m_win = m_win - 1;
            if (exp_now) m_st = 1'b1;
            else if (bus_wr && bus_addr == 8'h14 && bus_wdata[1]) m_st = 1'b0;
            if (wc) m_ctrl = bus_wdata[4:0];
            if (bus_wr && bus_addr == 8'h04) m_rel = bus_wdata;
            if (bus_wr && bus_addr == 8'h18) m_len = bus_wdata;
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    // continuous comparison against the model, just before each rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #(CLK_P/2 - 1);
            check("R8", {31'd0, wdt_rst_req}, {31'd0, m_req});
            check("R9", {31'd0, wdt_irq}, {31'd0, (m_win != 0) && m_ctrl[2]});
            check("R9", {31'd0, wdt_ext}, {31'd0, (m_win != 0) && m_ctrl[3]});
            check(bus_addr == 8'h00 ? "R5" : "R2", bus_rdata, m_read(bus_rd, bus_addr));
        end
    end

    task automatic step(logic wr, logic rd, logic [7:0] a, logic [31:0] d, logic tk);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_en = tk;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        step(1'b0, 1'b1, a, 32'd0, 1'b0);
        #(CLK_P/2 - 1);
        check(req, bus_rdata, exp);
    endtask

    task automatic out_chk(string req, logic r, logic i, logic e);
        step(1'b0, 1'b0, 8'h00, 32'd0, 1'b0);
        #(CLK_P/2 - 1);
        check(req, {29'd0, r, i, e}, {29'd0, wdt_rst_req, wdt_irq, wdt_ext} ^ {29'd0, r, i, e} ^ {29'd0, r, i, e});
        check(req, {29'd0, wdt_rst_req, wdt_irq, wdt_ext}, {29'd0, r, i, e});
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'd0, 1'b1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        out_chk("R1", 1'b0, 1'b0, 1'b0);
        rd_chk("R1", 8'h04, 32'h03EF_1480);
        rd_chk("R1", 8'h0C, 32'd0);
        rd_chk("R1", 8'h10, 32'd0);
        rd_chk("R1", 8'h18, 32'd4);
        // R2 constant, write-only and unmapped offsets
        rd_chk("R2", 8'h1C, 32'h0001_0601);
        rd_chk("R2", 8'h08, 32'd0);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h06, 32'h1234_5678);
        rd_chk("R2", 8'h24, 32'd0);
        rd_chk("R2", 8'h06, 32'd0);
        rd_chk("R2", 8'h04, 32'h03EF_1480);
        // R3 disabled counter read
        wr(8'h04, 32'd5);
        wr(8'h18, 32'd3);
        rd_chk("R3", 8'h00, 32'd5);
        // R6 kick while disabled ignored (counter not armed)
        wr(8'h08, KEY);
        rd_chk("R6", 8'h00, 32'd5);
        // R4 arm loads
        wr(8'h0C, 32'h0F);
        rd_chk("R4", 8'h00, 32'd5);
        ticks(2);
        rd_chk("R5", 8'h00, 32'd3);
        wr(8'h0C, 32'h0F);
        rd_chk("R4", 8'h00, 32'd3);
        wr(8'h08, 32'h0000_5AB8);
        rd_chk("R6", 8'h00, 32'd3);
        wr(8'h08, KEY);
        rd_chk("R6", 8'h00, 32'd5);
        // R5 stop
        ticks(1);
        wr(8'h0C, 32'h0E);
        ticks(3);
        rd_chk("R5", 8'h00, 32'd5);
        // R7 / R8 / R9 expiry with all alarms enabled
        wr(8'h0C, 32'h0F);
        ticks(5);
        out_chk("R8", 1'b1, 1'b1, 1'b1);
        out_chk("R8", 1'b0, 1'b1, 1'b1);
        rd_chk("R7", 8'h10, 32'd2);
        ticks(3);
        rd_chk("R7", 8'h00, 32'd0);
        out_chk("R9", 1'b0, 1'b0, 1'b0);
        // R8 reset request disabled: only interrupt
        wr(8'h0C, 32'h00);
        wr(8'h18, 32'd0);
        wr(8'h04, 32'd1);
        wr(8'h0C, 32'h05);
        ticks(1);
        out_chk("R8", 1'b0, 1'b1, 1'b0);
        ticks(1);
        out_chk("R9", 1'b0, 1'b0, 1'b0);
        // R10 expiry and clear in the same cycle: set wins
        wr(8'h0C, 32'h00);
        wr(8'h0C, 32'h01);
        step(1'b1, 1'b0, 8'h14, 32'd2, 1'b1);
        rd_chk("R10", 8'h10, 32'd2);
        wr(8'h14, 32'hFFFF_FFFD);
        rd_chk("R10", 8'h10, 32'd2);
        wr(8'h14, 32'd2);
        rd_chk("R10", 8'h10, 32'd0);
        // R11 kick on the final tick
        wr(8'h0C, 32'h00);
        wr(8'h04, 32'd3);
        wr(8'h0C, 32'h0F);
        ticks(2);
        step(1'b1, 1'b0, 8'h08, KEY, 1'b1);
        rd_chk("R11", 8'h00, 32'd3);
        rd_chk("R11", 8'h10, 32'd0);
        out_chk("R11", 1'b0, 1'b0, 1'b0);
        // R4 reload of zero loads one
        wr(8'h0C, 32'h00);
        wr(8'h04, 32'd0);
        rd_chk("R3", 8'h00, 32'd0);
        wr(8'h0C, 32'h01);
        rd_chk("R4", 8'h00, 32'd1);
        // random traffic judged by the model
        for (int n = 0; n < 6000; n++) begin
            int op;
            logic tk;
            op = $urandom % 12;
            tk = ($urandom % 10) < 7;
            case (op)
                4: step(1'b1, 1'b0, 8'h08, ($urandom % 4 != 0) ? KEY : $urandom, tk);
                5: step(1'b1, 1'b0, 8'h0C, {27'd0, 4'($urandom), ($urandom % 5) != 0}, tk);
                6: step(1'b1, 1'b0, 8'h04, $urandom % 12, tk);
                7: step(1'b1, 1'b0, 8'h18, $urandom % 5, tk);
                8: step(1'b1, 1'b0, 8'h14, $urandom, tk);
                9: step(1'b1, 1'b0, 8'($urandom % 48), $urandom, tk);
                10, 11: step(1'b0, 1'b1, 8'($urandom % 40), 32'd0, tk);
                default: step(1'b0, 1'b0, 8'h00, 32'd0, tk);
            endcase
        end
        step(1'b0, 1'b0, 8'h00, 32'd0, 1'b0);
        @(negedge clk);
        finish_run();
    end
endmodule